// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits in a byte-serial MPEG transport stream path and forwards only the 188-byte packets whose 13-bit packet identifier is wanted. Eight filter slots each hold a PID value and an enable flag. A packet is forwarded when its PID equals the PID of any enabled slot. Slot 0 also carries three global controls: a pass-everything flag, a block-everything flag and a byte-order select that is exported for the downstream word packer.

The incoming stream is qualified by a valid strobe, and a start marker flags the first byte of every packet. The block holds the sync byte and the two header bytes that carry the PID, and it decides when the second header byte arrives. It then either releases the whole packet into the output stream or discards it. A partial packet never reaches the output. Software sets up the slots through a simple word-addressed write/read port. The settings it writes are latched into the filter only when the next packet starts, so a packet is always judged against one consistent set of settings.

Top module: `ts_pid_gate`

## Requirements
- R1: After reset every slot reads back 0x00001FFF, meaning PID field all ones and every flag clear. `out_valid` stays low and `byte_order` is 0.
- R2: A write at byte address n*4 (address bits 4:2 select slot n) stores the slot. A read returns the PID in bits 12:0 and the enable in bit 15. For slot 0 only, the read also returns block-all in bit 13, byte order in bit 14 and pass-all in bit 16. Every other bit reads 0.
- R3: A packet whose first byte is 0x47 is forwarded when its PID equals the PID of an enabled slot. The PID is the low 5 bits of byte 1 followed by all of byte 2. A forwarded packet comes out in full: all 188 bytes, in order, with `out_start` set only on the first byte.
- R4: A slot whose enable is clear never matches, even for the null PID 0x1FFF held by a released slot. A packet that matches no enabled slot is dropped completely.
- R5: When pass-all is set, every packet that starts with 0x47 is forwarded, whatever the slots and block-all hold.
- R6: When block-all is set and pass-all is clear, no packet is forwarded, even one that matches an enabled slot.
- R7: A packet whose first byte is not 0x47 produces no output. The block ignores the stream until the next start marker.
- R8: Settings written while a packet is in progress do not affect that packet. They take effect from the next start marker.
- R9: `byte_order` equals the byte-order bit of slot 0 as latched at the most recent start marker, and it changes only at a start marker.
- R10: A start marker that arrives early ends the current packet. If the PID was already decided, the bytes released so far stay in the output; if the header was incomplete, nothing is output. Bytes after the 188th are ignored.
- R11: Back-to-back packets arriving at one byte per cycle are forwarded without any loss of bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_start | input | 1 | Input byte is the first of a packet (qualified by in_valid) |
| in_data | input | 8 | Input stream byte |
| reg_wr | input | 1 | Slot register write strobe |
| reg_addr | input | 5 | Byte address of the slot register (n*4) |
| reg_wdata | input | 32 | Slot register write data |
| reg_rdata | output | 32 | Slot register read data for reg_addr |
| out_valid | output | 1 | Output byte valid |
| out_start | output | 1 | Output byte is the first of a packet |
| out_data | output | 8 | Output stream byte |
| byte_order | output | 1 | Byte-order select in effect for the current packet |

## Verification
The assertions rely on the source producing at most one byte per cycle and on `in_start` counting only when `in_valid` is also set. They also rely on the byte-order flag moving only when such a start byte is accepted. The stimulus drives `in_start` only together with `in_valid` on the first byte of a packet. It always supplies the low address bits as zero, and when it writes in the middle of a packet it does so on a cycle that also carries a stream byte, so the latching rule is exercised at its edge.

// File: rtl/ts_pid_gate.sv
module ts_pid_gate #(
  parameter int SLOTS      = 8,
  parameter int PID_W      = 13,
  parameter int PKT_LEN    = 188,
  parameter int FIFO_DEPTH = 4,
  localparam int AW        = $clog2(SLOTS) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic [7:0]    in_data,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          out_valid,
  output logic          out_start,
  output logic [7:0]    out_data,
  output logic          byte_order
);
  localparam int SW    = $clog2(SLOTS);
  localparam int FP_W  = $clog2(FIFO_DEPTH);
  localparam int FC_W  = FP_W + 1;
  localparam int IDX_W = $clog2(PKT_LEN);
  localparam int HI_W  = PID_W - 8;
  localparam int B_ALL = 16;
  localparam int B_EN  = 15;
  localparam int B_ORD = 14;
  localparam int B_BLK = 13;
  localparam logic [7:0] SYNC = 8'h47;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PASS} st_t;

  logic [PID_W-1:0] sh_pid [SLOTS];
  logic [PID_W-1:0] ac_pid [SLOTS];
  logic [SLOTS-1:0] sh_en, ac_en, hit;
  logic sh_all, sh_blk, sh_ord, ac_all, ac_blk, ac_ord;

  logic [SW-1:0] wsel, rsel;
  assign wsel = reg_addr[AW-1:2];
  assign rsel = reg_addr[AW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) sh_pid[i] <= '1;
      sh_en  <= '0;
      sh_all <= 1'b0;
      sh_blk <= 1'b0;
      sh_ord <= 1'b0;
    end else if (reg_wr) begin
      sh_pid[wsel] <= reg_wdata[PID_W-1:0];
      sh_en[wsel]  <= reg_wdata[B_EN];
      if (wsel == '0) begin
        sh_all <= reg_wdata[B_ALL];
        sh_blk <= reg_wdata[B_BLK];
        sh_ord <= reg_wdata[B_ORD];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[PID_W-1:0] = sh_pid[rsel];
    reg_rdata[B_EN] = sh_en[rsel];
    if (rsel == '0) begin
      reg_rdata[B_ALL] = sh_all;
      reg_rdata[B_BLK] = sh_blk;
      reg_rdata[B_ORD] = sh_ord;
    end
  end

  wire take = in_valid && in_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) ac_pid[i] <= '1;
      ac_en  <= '0;
      ac_all <= 1'b0;
      ac_blk <= 1'b0;
      ac_ord <= 1'b0;
    end else if (take) begin
      for (int i = 0; i < SLOTS; i++) ac_pid[i] <= sh_pid[i];
      ac_en  <= sh_en;
      ac_all <= sh_all;
      ac_blk <= sh_blk;
      ac_ord <= sh_ord;
    end
  end

  assign byte_order = ac_ord;

  logic [HI_W-1:0]  pid_hi;
  logic [PID_W-1:0] pid_now;
  assign pid_now = {pid_hi, in_data};

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign hit[g] = ac_en[g] && (ac_pid[g] == pid_now);
  end

  wire pass_now = ac_all || (!ac_blk && (|hit));

  st_t st, st_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic [8:0]       mem [FIFO_DEPTH];
  logic [FP_W-1:0]  wp, rp, wp_base;
  logic [FC_W-1:0]  cnt, rel, unrel, cnt_base, cnt_n, rel_n;
  logic push, push_rel, undo, rel_all, pop;

  assign pop   = (rel != '0);
  assign unrel = cnt - rel;

  always_comb begin
    push     = 1'b0;
    push_rel = 1'b0;
    undo     = 1'b0;
    rel_all  = 1'b0;
    st_n     = st;
    idx_n    = idx;
    if (in_valid) begin
      if (in_start) begin
        undo  = 1'b1;
        idx_n = IDX_W'(1);
        if (in_data == SYNC) begin
          push = 1'b1;
          st_n = S_HDR;
        end else begin
          st_n = S_IDLE;
        end
      end else begin
        case (st)
          S_HDR: begin
            idx_n = idx + 1'b1;
            if (idx == IDX_W'(1)) begin
              push = 1'b1;
            end else if (pass_now) begin
              push    = 1'b1;
              rel_all = 1'b1;
              st_n    = S_PASS;
            end else begin
              undo = 1'b1;
              st_n = S_IDLE;
            end
          end
          S_PASS: begin
            push     = 1'b1;
            push_rel = 1'b1;
            idx_n    = idx + 1'b1;
            if (idx == IDX_W'(PKT_LEN - 1)) st_n = S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    wp_base  = undo ? wp - FP_W'(unrel) : wp;
    cnt_base = undo ? rel : cnt;
    cnt_n    = cnt_base + FC_W'(push) - FC_W'(pop);
    rel_n    = rel_all ? cnt_n : rel + FC_W'(push_rel) - FC_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      pid_hi <= '0;
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      rel    <= '0;
      for (int i = 0; i < FIFO_DEPTH; i++) mem[i] <= '0;
    end else begin
      st  <= st_n;
      idx <= idx_n;
      if (in_valid && !in_start && st == S_HDR && idx == IDX_W'(1))
        pid_hi <= in_data[HI_W-1:0];
      if (push) mem[wp_base] <= {in_start, in_data};
      wp  <= wp_base + FP_W'(push);
      rp  <= rp + FP_W'(pop);
      cnt <= cnt_n;
      rel <= rel_n;
    end
  end

  assign out_valid = pop;
  assign out_start = mem[rp][8];
  assign out_data  = mem[rp][7:0];
endmodule

// File: rtl/ts_pid_gate_chk.sv
module ts_pid_gate_chk #(
  parameter int AW         = 5,
  parameter int FC_W       = 3,
  parameter int FIFO_DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_start,
  input logic          out_valid,
  input logic          out_start,
  input logic [7:0]    out_data,
  input logic          byte_order,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_rdata,
  input logic [FC_W-1:0] fifo_cnt
);
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:17] == '0); // R2

  AST_SLOT_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[AW-1:2] != '0) |-> (reg_rdata[16] == 1'b0 && reg_rdata[14:13] == 2'b00)); // R2

  AST_OUT_START_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_start) |-> (out_data == 8'h47)); // R7

  AST_ORDER_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_start) |=> $stable(byte_order)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt < FC_W'(FIFO_DEPTH)); // R11
endmodule

bind ts_pid_gate ts_pid_gate_chk #(.AW(AW), .FC_W(FC_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
  .out_valid(out_valid), .out_start(out_start), .out_data(out_data),
  .byte_order(byte_order), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .fifo_cnt(cnt)
);

// File: tb/ts_pid_gate_bench.sv
module ts_pid_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_start = 1'b0;
  logic [7:0]  in_data = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        out_valid, out_start, byte_order;
  logic [7:0]  out_data;

  int checks = 0, fails = 0;
  logic [31:0] m_sh [8];
  logic [31:0] m_ac [8];
  logic [8:0]  expq[$];
  logic [8:0]  gotq[$];
  int unsigned seed = 32'h1234abcd;

  always #10 clk = ~clk;

  ts_pid_gate u_ts_pid_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_data(in_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .out_valid(out_valid),
    .out_start(out_start), .out_data(out_data), .byte_order(byte_order)
  );

  always @(negedge clk)
    if (rst_n && out_valid) gotq.push_back({out_start, out_data});

  function automatic logic [31:0] mask_of(int s, logic [31:0] v);
    return v & ((s == 0) ? 32'h0001FFFF : 32'h00009FFF);
  endfunction

  function automatic bit m_pass(int pid);
    if (m_ac[0][16]) return 1'b1;
    if (m_ac[0][13]) return 1'b0;
    for (int i = 0; i < 8; i++)
      if (m_ac[i][15] && m_ac[i][12:0] == pid[12:0]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(int s, logic [31:0] v);
    reg_wr = 1'b1; reg_addr = 5'(s * 4); reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    m_sh[s] = mask_of(s, v);
  endtask

  task automatic check_read(int s, string req);
    reg_addr = 5'(s * 4);
    #1;
    check(reg_rdata == m_sh[s], req, "slot readback", reg_rdata, m_sh[s]);
    @(negedge clk);
  endtask

  task automatic send_pkt(int pid, logic [7:0] sync, int len, bit gaps,
                          int mid_slot, logic [31:0] mid_val, bit chk_ord);
    bit ok;
    logic [7:0] b;
    for (int i = 0; i < 8; i++) m_ac[i] = m_sh[i];
    ok = (sync == 8'h47) && (len >= 3) && m_pass(pid);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom(seed) % 4 == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      if (i == 0)      b = sync;
      else if (i == 1) b = {3'($urandom(seed)), 5'(pid >> 8)};
      else if (i == 2) b = 8'(pid);
      else             b = 8'($urandom(seed));
      if (i == 120 && chk_ord)
        check(byte_order == m_ac[0][14], "R9", "byte_order mid packet", 32'(byte_order), 32'(m_ac[0][14]));
      in_valid = 1'b1; in_start = (i == 0); in_data = b;
      if (i == 100 && mid_slot >= 0) begin
        reg_wr = 1'b1; reg_addr = 5'(mid_slot * 4); reg_wdata = mid_val;
      end
      if (ok && i < 188) expq.push_back({(i == 0), b});
      @(negedge clk);
      if (i == 100 && mid_slot >= 0) begin
        reg_wr = 1'b0;
        m_sh[mid_slot] = mask_of(mid_slot, mid_val);
      end
    end
    in_valid = 1'b0; in_start = 1'b0;
  endtask

  task automatic check_stream(string req, string what);
    bit same;
    repeat (8) @(negedge clk);
    same = (gotq.size() == expq.size());
    if (same)
      foreach (expq[i]) if (gotq[i] !== expq[i]) same = 1'b0;
    check(same, req, what, 32'(gotq.size()), 32'(expq.size()));
    gotq.delete();
    expq.delete();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_sh[i] = 32'h1FFF; m_ac[i] = 32'h1FFF; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
    check(byte_order == 1'b0, "R1", "byte_order after reset", 32'(byte_order), 0);
    for (int s = 0; s < 8; s++) check_read(s, "R1");

    send_pkt(13'h0100, 8'h47, 188, 0, -1, 0, 0);
    check_stream("R1", "no output with reset settings");

    reg_write(0, 32'h0001FFFF);
    check_read(0, "R2");
    reg_write(5, 32'hFFFFFFFF);
    check_read(5, "R2");
    reg_write(0, 32'h00001FFF);
    reg_write(5, 32'h00001FFF);
    check_read(0, "R2");

    reg_write(3, 32'h00008100);
    reg_write(6, 32'h00008ABC);
    send_pkt(13'h0100, 8'h47, 188, 0, -1, 0, 0);
    check_stream("R3", "matching packet slot3");
    send_pkt(13'h0ABC, 8'h47, 188, 1, -1, 0, 0);
    check_stream("R3", "matching packet slot6 with gaps");

    send_pkt(13'h1FFF, 8'h47, 188, 0, -1, 0, 0);
    check_stream("R4", "null PID against released slots");
    send_pkt(13'h0101, 8'h47, 188, 0, -1, 0, 0);
    check_stream("R4", "unmatched PID dropped");
    reg_write(3, 32'h00000100);
    send_pkt(13'h0100, 8'h47, 188, 0, -1, 0, 0);
    check_stream("R4", "disabled slot with equal PID");
    reg_write(3, 32'h00008100);

    reg_write(0, 32'h00016000);
    send_pkt(13'h0777, 8'h47, 188, 0, -1, 0, 1);
    send_pkt(13'h1FFF, 8'h47, 188, 0, -1, 0, 1);
    check_stream("R5", "pass-all overrides block-all");

    reg_write(0, 32'h00002000);
    send_pkt(13'h0100, 8'h47, 188, 0, -1, 0, 1);
    check_stream("R6", "block-all drops match");

    reg_write(0, 32'h00010000);
    send_pkt(13'h0100, 8'h46, 188, 0, -1, 0, 0);
    send_pkt(13'h0100, 8'h00, 188, 1, -1, 0, 0);
    check_stream("R7", "bad sync dropped");

    reg_write(0, 32'h00000000);
    send_pkt(13'h0100, 8'h47, 188, 0, 3, 32'h00001FFF, 1);
    check_stream("R8", "mid-packet release keeps packet");
    send_pkt(13'h0100, 8'h47, 188, 0, -1, 0, 1);
    check_stream("R8", "release applies at next packet");
    reg_write(3, 32'h00008100);

    send_pkt(13'h0100, 8'h47, 188, 0, 0, 32'h00004000, 1);
    check(byte_order == 1'b0, "R9", "byte_order holds after mid write", 32'(byte_order), 0);
    send_pkt(13'h0100, 8'h47, 188, 0, -1, 0, 1);
    check(byte_order == 1'b1, "R9", "byte_order after next start", 32'(byte_order), 1);
    check_stream("R9", "stream during order change");

    send_pkt(13'h0100, 8'h47, 2, 0, -1, 0, 0);
    send_pkt(13'h0100, 8'h47, 100, 0, -1, 0, 0);
    send_pkt(13'h0ABC, 8'h47, 200, 0, -1, 0, 0);
    send_pkt(13'h0ABC, 8'h47, 188, 0, -1, 0, 0);
    check_stream("R10", "truncated and over-long packets");

    for (int n = 0; n < 6; n++) begin
      reg_write(0, {15'd0, ($urandom(seed) % 6 == 0), 1'b0, 1'b0, ($urandom(seed) % 6 == 0), 13'h1FFF});
      for (int s = 1; s < 8; s++)
        reg_write(s, {16'd0, 1'($urandom(seed)), 2'b00, 13'($urandom(seed) % 16)});
      for (int p = 0; p < 8; p++)
        send_pkt(int'($urandom(seed) % 16), 8'h47, 188, (n % 2 == 1), -1, 0, 0);
      check_stream("R11", "random back-to-back batch");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog expired: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule